// File: doc/BRIEF.md
# H-Bridge Input Decode Controller

This block sits between logic-level motor-control pins and the gate drivers of a full H-bridge. It produces four registered switch enables, a high-side and a low-side one for each of the two half-bridges. Each half-bridge output is in one of three states. It is driven high when only its high-side switch is on. It is driven low when only its low-side switch is on. It is high-impedance when both of its switches are off.

A build-time parameter selects how the two control inputs `ctl_a` and `ctl_b` are read:
- In direct mode, each input steers one output.
- In direction/gate mode, `ctl_a` gives the rotation direction and `ctl_b` gates the bridge.

The block also does three more things:
- It observes an active-low sleep input.
- It holds the bridge off for a parameterised wake interval, counted in clock cycles, after sleep is released.
- It forces all switches off while the fault input is high.

Whenever one half-bridge would swap from driving high to driving low, or from low to high, it passes through one cycle with both of its switches off.

Top module: `hbridge_decode`

## Requirements
- R1: While reset is held, and after reset is released with sleep low, all four enables are 0.
- R2: Sleep low at a clock edge turns all four enables off after that edge, whatever `ctl_a`, `ctl_b` and `fault` are.
- R3: Direct mode, once settled: inputs (0,0) give both outputs Z (vector `{hs1,ls1,hs2,ls2}` = 0000), and inputs (1,1) give both outputs low (0101).
- R4: Direct mode, once settled: `ctl_a`=1 with `ctl_b`=0 gives output 1 high and output 2 low (1001). `ctl_a`=0 with `ctl_b`=1 gives output 1 low and output 2 high (0110).
- R5: Direction/gate mode: `ctl_b`=0 gives both outputs low (0101) whatever `ctl_a` is.
- R6: Direction/gate mode with `ctl_b`=1: `ctl_a`=0 gives 1001 and `ctl_a`=1 gives 0110.
- R7: After sleep rises, the enables stay 0 for `WAKE_CYCLES` clock edges. The decoded state appears after the next edge. The count starts again from zero whenever sleep is low at an edge.
- R8: Fault high at an edge turns all enables off after that edge. Once fault is low again, the decoded state returns one edge later.
- R9: The high-side and low-side enables of the same half-bridge are never both 1.
- R10: When a half-bridge moves between driven-high and driven-low, it spends exactly one cycle with both switches off before the new switch turns on. Every other change takes effect one edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| sleep_n | input | 1 | Active-low sleep request |
| fault | input | 1 | Combined protection fault; high forces the bridge off |
| ctl_a | input | 1 | Output-1 input (direct) or direction (direction/gate) |
| ctl_b | input | 1 | Output-2 input (direct) or bridge gate (direction/gate) |
| hs1_en | output | 1 | High-side switch enable, half-bridge 1 |
| ls1_en | output | 1 | Low-side switch enable, half-bridge 1 |
| hs2_en | output | 1 | High-side switch enable, half-bridge 2 |
| ls2_en | output | 1 | Low-side switch enable, half-bridge 2 |

## Verification
The assertions assume that the control, sleep and fault inputs are synchronous to `clk`, and that they are sampled once per edge without metastability. They also assume that `rst_n` is low from time zero. The bench meets these assumptions in two ways. Every input is changed one nanosecond after a rising edge, and reset is held low from the start. The bench then runs the same stimulus into one instance built in each interface mode. It compares both against a model of the three-state outputs and the one-cycle dead time, with a short wake interval so that the full wake count can be observed.

// File: rtl/hbridge_decode.sv
module hbridge_decode #(
  parameter bit PHASE_ENABLE = 1'b0,
  parameter int WAKE_CYCLES  = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic fault,
  input  logic ctl_a,
  input  logic ctl_b,
  output logic hs1_en,
  output logic ls1_en,
  output logic hs2_en,
  output logic ls2_en
);
  localparam int CW = $clog2(WAKE_CYCLES + 2);
  localparam logic [CW-1:0] WAKE_END = CW'(WAKE_CYCLES);

  typedef enum logic [1:0] {DRV_OFF = 2'd0, DRV_HI = 2'd1, DRV_LO = 2'd2} drive_t;

  logic [CW-1:0] wake_cnt;
  drive_t        tgt1, tgt2, dec1, dec2, st1, st2;
  logic          ready, run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  wake_cnt <= '0;
    else if (!sleep_n)           wake_cnt <= '0;
    else if (wake_cnt != WAKE_END) wake_cnt <= wake_cnt + 1'b1;

  assign ready = sleep_n && (wake_cnt == WAKE_END);
  assign run   = ready && !fault;

  generate
    if (PHASE_ENABLE) begin : g_dir_gate
      assign dec1 = (ctl_b && !ctl_a) ? DRV_HI : DRV_LO;
      assign dec2 = (ctl_b &&  ctl_a) ? DRV_HI : DRV_LO;
    end else begin : g_direct
      assign dec1 = (ctl_a && !ctl_b) ? DRV_HI : (ctl_b ? DRV_LO : DRV_OFF);
      assign dec2 = (ctl_b && !ctl_a) ? DRV_HI : (ctl_a ? DRV_LO : DRV_OFF);
    end
  endgenerate

  assign tgt1 = run ? dec1 : DRV_OFF;
  assign tgt2 = run ? dec2 : DRV_OFF;

  function automatic drive_t step(drive_t cur, drive_t tgt);
    if (cur != DRV_OFF && tgt != DRV_OFF && cur != tgt) return DRV_OFF;
    return tgt;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st1 <= DRV_OFF;
      st2 <= DRV_OFF;
    end else begin
      st1 <= step(st1, tgt1);
      st2 <= step(st2, tgt2);
    end

  assign hs1_en = (st1 == DRV_HI);
  assign ls1_en = (st1 == DRV_LO);
  assign hs2_en = (st2 == DRV_HI);
  assign ls2_en = (st2 == DRV_LO);

  a_r9_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs1_en && ls1_en) && !(hs2_en && ls2_en));

  a_r10_dead_hs1: assert property (@(posedge clk) disable iff (!rst_n) hs1_en |=> !ls1_en);
  a_r10_dead_ls1: assert property (@(posedge clk) disable iff (!rst_n) ls1_en |=> !hs1_en);
  a_r10_dead_hs2: assert property (@(posedge clk) disable iff (!rst_n) hs2_en |=> !ls2_en);
  a_r10_dead_ls2: assert property (@(posedge clk) disable iff (!rst_n) ls2_en |=> !hs2_en);

  a_r2_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !(hs1_en || ls1_en || hs2_en || ls2_en));

  a_r8_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !(hs1_en || ls1_en || hs2_en || ls2_en));

  a_r7_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cnt != WAKE_END) |=> !(hs1_en || ls1_en || hs2_en || ls2_en));

  generate
    if (PHASE_ENABLE) begin : g_chk_dir_gate
      a_r5_gate_low_brake: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctl_b) |=> !hs1_en && !hs2_en);
    end else begin : g_chk_direct
      a_r3_both_high_brake: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl_a && ctl_b) |=> !hs1_en && !hs2_en);
      a_r3_both_low_coast: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctl_a && !ctl_b) |=> !(hs1_en || ls1_en || hs2_en || ls2_en));
    end
  endgenerate
endmodule

// File: tb/hbridge_decode_test.sv
`timescale 1ns/100ps
module hbridge_decode_test;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sleep_n = 1'b0, fault = 1'b0, ctl_a = 1'b0, ctl_b = 1'b0;
  logic h1d, l1d, h2d, l2d, h1p, l1p, h2p, l2p;
  int   n_checks = 0, n_fail = 0;
  logic [3:0] exp_d = 4'b0000, exp_p = 4'b0000;

  always #2.5 clk = ~clk;

  hbridge_decode #(.PHASE_ENABLE(1'b0), .WAKE_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fault(fault), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .hs1_en(h1d), .ls1_en(l1d), .hs2_en(h2d), .ls2_en(l2d));

  hbridge_decode #(.PHASE_ENABLE(1'b1), .WAKE_CYCLES(W)) uut_pe (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fault(fault), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .hs1_en(h1p), .ls1_en(l1p), .hs2_en(h2p), .ls2_en(l2p));

  function automatic logic [3:0] decode(bit pe, logic a, logic b);
    if (pe) return !b ? 4'b0101 : (a ? 4'b0110 : 4'b1001);
    case ({a, b})
      2'b00:   return 4'b0000;
      2'b01:   return 4'b0110;
      2'b10:   return 4'b1001;
      default: return 4'b0101;
    endcase
  endfunction

  function automatic logic [1:0] half_step(logic [1:0] cur, logic [1:0] tgt);
    if (cur != 2'b00 && tgt != 2'b00 && cur != tgt) return 2'b00;
    return tgt;
  endfunction

  function automatic logic [3:0] step4(logic [3:0] cur, logic [3:0] tgt);
    return {half_step(cur[3:2], tgt[3:2]), half_step(cur[1:0], tgt[1:0])};
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp, string which);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] got=%b expected=%b at %0t", req, which, got, exp, $time);
    end
    n_checks++;
    if ((got[3] && got[2]) || (got[1] && got[0])) begin
      n_fail++;
      $display("FAIL R9 [%s] got=%b expected=no half with both switches on", which, got);
    end
  endtask

  task automatic check_both(string req);
    check(req, {h1d, l1d, h2d, l2d}, exp_d, "direct");
    check(req, {h1p, l1p, h2p, l2p}, exp_p, "dir_gate");
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check_both("R1");
    rst_n = 1'b1;
    edge_wait();
    check_both("R1");
  endtask

  task automatic t_wake(logic a, logic b);
    ctl_a = a; ctl_b = b; sleep_n = 1'b1;
    for (int i = 0; i < W; i++) begin
      edge_wait();
      check_both("R7");
    end
    edge_wait();
    exp_d = decode(1'b0, a, b);
    exp_p = decode(1'b1, a, b);
    check_both("R7");
  endtask

  task automatic t_apply(logic a, logic b);
    string rd, rp;
    logic [3:0] td, tp;
    td = decode(1'b0, a, b);
    tp = decode(1'b1, a, b);
    ctl_a = a; ctl_b = b;
    edge_wait();
    exp_d = step4(exp_d, td);
    exp_p = step4(exp_p, tp);
    check_both("R10");
    edge_wait();
    exp_d = td; exp_p = tp;
    rd = (a == b) ? "R3" : "R4";
    rp = !b ? "R5" : "R6";
    check(rd, {h1d, l1d, h2d, l2d}, exp_d, "direct");
    check(rp, {h1p, l1p, h2p, l2p}, exp_p, "dir_gate");
  endtask

  task automatic t_dead_exact();
    t_apply(1'b1, 1'b0);
    ctl_a = 1'b0; ctl_b = 1'b1;
    edge_wait();
    check("R10", {h1d, l1d, h2d, l2d}, 4'b0000, "direct reversal gap");
    edge_wait();
    check("R10", {h1d, l1d, h2d, l2d}, 4'b0110, "direct reversal done");
    exp_d = 4'b0110; exp_p = decode(1'b1, 1'b0, 1'b1);
    ctl_a = 1'b1;
    edge_wait();
    check("R10", {h1p, l1p, h2p, l2p}, 4'b0000, "dir_gate reversal gap");
    edge_wait();
    check("R10", {h1p, l1p, h2p, l2p}, 4'b0110, "dir_gate reversal done");
    exp_p = 4'b0110; exp_d = 4'b0101;
    check("R3", {h1d, l1d, h2d, l2d}, exp_d, "direct brake after reversal");
  endtask

  task automatic t_fault();
    fault = 1'b1;
    edge_wait();
    exp_d = 4'b0000; exp_p = 4'b0000;
    check_both("R8");
    ctl_a = ~ctl_a;
    edge_wait();
    check_both("R8");
    fault = 1'b0;
    edge_wait();
    exp_d = decode(1'b0, ctl_a, ctl_b);
    exp_p = decode(1'b1, ctl_a, ctl_b);
    check_both("R8");
  endtask

  task automatic t_sleep();
    sleep_n = 1'b0;
    edge_wait();
    exp_d = 4'b0000; exp_p = 4'b0000;
    check_both("R2");
    ctl_a = 1'b1; ctl_b = 1'b0;
    edge_wait();
    check_both("R2");
  endtask

  task automatic t_rewake_interrupt();
    sleep_n = 1'b1;
    repeat (W - 2) begin
      edge_wait();
      check_both("R7");
    end
    sleep_n = 1'b0;
    edge_wait();
    check_both("R2");
    t_wake(1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_wake(1'b1, 1'b1);
    t_apply(1'b0, 1'b1);
    t_apply(1'b1, 1'b1);
    t_apply(1'b0, 1'b0);
    t_apply(1'b1, 1'b0);
    t_apply(1'b0, 1'b1);
    t_apply(1'b1, 1'b0);
    t_apply(1'b0, 1'b0);
    t_dead_exact();
    t_fault();
    t_sleep();
    t_wake(1'b1, 1'b0);
    t_sleep();
    t_rewake_interrupt();
    t_apply(1'b1, 1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule